// File: doc/BRIEF.md
# Range-Scaled Visible Watermark Pixel Embedder

This block blends a visible watermark into an 8-bit grayscale image one pixel at a time. Each cycle it can accept one host pixel together with the watermark pixel at the same position. Comparators against three programmable gray thresholds place the host value in one of four brightness bands. Each band has its own scaling coefficient, and the selected coefficient stands in for a perceptual cube-root curve with a piecewise-linear fit.

A three-stage pipeline produces the output. The first stage forms two products: the band coefficient times the host value, and a user strength times the watermark value. The second stage multiplies those two products together. The third stage drops the fraction bits, adds the result to the host value and saturates the sum. A small constant store holds the four coefficients and the three thresholds. The store has one write and read port that can be used at any time, even while pixels are flowing. The strength comes in on its own port, so it can change from one pixel to the next.

Top module: `vis_wm_embedder`

## Requirements
- R1: After reset, out_valid and out_pix are 0. The constant store then reads back coefficients 87, 56, 48 and 44 at addresses 0 to 3, and thresholds 64, 128 and 192 at addresses 4 to 6.
- R2: A write with cfg_we high updates the word at cfg_addr. Addresses 0 to 3 are the coefficients for the lowest to highest band, and addresses 4 to 6 are the thresholds in ascending order. cfg_rdata shows the word at cfg_addr combinationally. Address 7 reads 0, and a write to address 7 changes no stored word.
- R3: The host value h selects band 0 when h < T0, band 1 when T0 <= h < T1, band 2 when T1 <= h < T2, and band 3 when h >= T2. A pixel equal to a threshold therefore falls in the upper band.
- R4: The output pixel is h + floor(C*h*S*W / 65536). Here C is the band coefficient, S is wm_strength and W is the watermark pixel, and C and S are unsigned fractions with 8 fraction bits.
- R5: When the sum in R4 exceeds 255, the output is 255. It never wraps.
- R6: A pixel accepted at one clock edge appears, with out_valid high, after the third edge that follows. A new pixel can be accepted on every cycle. When in_valid is low, out_valid is low three cycles later.
- R7: When the watermark pixel or wm_strength is 0, the output equals the host pixel.
- R8: A pixel presented in the same cycle as a store write uses the old word. A pixel presented in any later cycle uses the new word.
- R9: While out_valid is low, out_pix keeps the last valid output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Host/watermark pair is valid |
| in_host | input | 8 | Host gray value |
| in_wm | input | 8 | Watermark gray value |
| wm_strength | input | 8 | Watermark strength, fraction of 256 |
| cfg_we | input | 1 | Store write enable |
| cfg_addr | input | 3 | Store address |
| cfg_wdata | input | 8 | Store write data |
| cfg_rdata | output | 8 | Store read data |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 8 | Watermarked gray value |

## Verification
Every host value from 0 to 255 is paired with watermark values 0, 1, 37, 128, 200 and 255 and strengths 0, 8, 128 and 255, with idle cycles spread through the stream. The complete host sweep reaches both sides of every threshold, so a wrong comparison at a band edge shows up. Zero watermark and zero strength separate the pass-through path from the multiply path. Full-scale values separate saturation from wrap-around. A second sweep uses close, uneven thresholds and extreme coefficients, including 0 and 255, to expose a band being swapped for another. A write issued in the same cycle as a pixel shows whether the old or the new coefficient was applied.

// File: rtl/vwm_pkg.sv
package vwm_pkg;

  // Fixed-point defaults of the band coefficients (fractions of 256).
  function automatic logic [7:0] dflt_coef(input int band, input int nbands);
    int k;
    k = (band * 4) / nbands;
    case (k)
      0:       return 8'd87;
      1:       return 8'd56;
      2:       return 8'd48;
      default: return 8'd44;
    endcase
  endfunction

  // Reset word of store entry idx: coefficients first, then thresholds.
  function automatic logic [15:0] rf_reset_word(input int idx, input int nbands,
                                                input int pix_w);
    if (idx < nbands) return 16'(dflt_coef(idx, nbands));
    return 16'(((idx - nbands + 1) << pix_w) / nbands);
  endfunction

endpackage

// File: rtl/vwm_const_rf.sv
module vwm_const_rf #(
  parameter int NUM_BANDS = 4,
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 8,
  parameter int AW        = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [AW-1:0]                    addr,
  input  logic [COEF_W-1:0]                wdata,
  output logic [COEF_W-1:0]                rdata,
  output logic [NUM_BANDS-1:0][COEF_W-1:0] coef_vec,
  output logic [NUM_BANDS-2:0][PIX_W-1:0]  thr_vec
);
  import vwm_pkg::*;

  localparam int NENT = 2 * NUM_BANDS - 1;

  logic [COEF_W-1:0] regs [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    localparam logic [15:0] RST_W = rf_reset_word(i, NUM_BANDS, PIX_W);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RST_W[COEF_W-1:0];
      else if (we && (int'(addr) == i))
        regs[i] <= wdata;
    end
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_coef
    assign coef_vec[b] = regs[b];
  end

  for (genvar t = 0; t < NUM_BANDS - 1; t++) begin : g_thr
    assign thr_vec[t] = regs[NUM_BANDS + t][PIX_W-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NENT; i++)
      if (int'(addr) == i) rdata = regs[i];
  end

  // A write to a mapped address lands in the store on the next cycle.
  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(addr) < NENT)) |=> (rdata == $past(wdata)) || (addr != $past(addr))); // R2

endmodule

// File: rtl/vwm_range_sel.sv
module vwm_range_sel #(
  parameter int NUM_BANDS = 4,
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 8
) (
  input  logic [PIX_W-1:0]                 host,
  input  logic [NUM_BANDS-2:0][PIX_W-1:0]  thr_vec,
  input  logic [NUM_BANDS-1:0][COEF_W-1:0] coef_vec,
  output logic [COEF_W-1:0]                coef_sel
);
  localparam int IDX_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1;

  logic [NUM_BANDS-2:0] at_or_above;
  logic [IDX_W-1:0]     band_idx;
  logic                 thr_ascending;
  logic                 lo_ok;
  logic                 hi_ok;

  // One comparator per threshold; equality counts as the upper band.
  for (genvar t = 0; t < NUM_BANDS - 1; t++) begin : g_cmp
    assign at_or_above[t] = (host >= thr_vec[t]);
  end

  always_comb begin
    int cnt;
    cnt = 0;
    for (int t = 0; t < NUM_BANDS - 1; t++)
      cnt += int'(at_or_above[t]);
    band_idx = IDX_W'(cnt);
  end

  always_comb begin
    coef_sel = '0;
    for (int b = 0; b < NUM_BANDS; b++)
      if (int'(band_idx) == b) coef_sel = coef_vec[b];
  end

  // Band bound check, meaningful when the thresholds are strictly ascending.
  always_comb begin
    thr_ascending = 1'b1;
    for (int t = 0; t < NUM_BANDS - 2; t++)
      if (thr_vec[t] >= thr_vec[t+1]) thr_ascending = 1'b0;
  end

  always_comb begin
    lo_ok = 1'b1;
    hi_ok = 1'b1;
    for (int t = 0; t < NUM_BANDS - 1; t++) begin
      if ((int'(band_idx) == t + 1) && (host < thr_vec[t]))  lo_ok = 1'b0;
      if ((int'(band_idx) == t)     && (host >= thr_vec[t])) hi_ok = 1'b0;
    end
  end

  always_comb begin
    if (thr_ascending) begin
      AST_BAND_BOUNDS: assert (lo_ok && hi_ok); // R3
    end
  end

endmodule

// File: rtl/vwm_mac_pipe.sv
module vwm_mac_pipe #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_host,
  input  logic [PIX_W-1:0]  in_wm,
  input  logic [COEF_W-1:0] coef,
  input  logic [COEF_W-1:0] strength,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int PW   = COEF_W + PIX_W;   // one scaled product
  localparam int QW   = 2 * PW;           // product of products
  localparam int FRAC = 2 * COEF_W;       // fraction bits in QW
  localparam int DW   = QW - FRAC;        // integer part width
  localparam int SW   = DW + 1;           // sum width
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  function automatic logic [PW-1:0] f_scale(input logic [COEF_W-1:0] k,
                                            input logic [PIX_W-1:0] v);
    return PW'(k) * PW'(v);
  endfunction

  function automatic logic [DW-1:0] f_merge(input logic [PW-1:0] a,
                                            input logic [PW-1:0] b);
    logic [QW-1:0] full;
    full = QW'(a) * QW'(b);
    return full[QW-1:FRAC];
  endfunction

  function automatic logic [PIX_W-1:0] f_sat_add(input logic [PIX_W-1:0] h,
                                                 input logic [DW-1:0] d);
    logic [SW-1:0] s;
    s = SW'(h) + SW'(d);
    if (s > SW'(PIX_MAX)) return PIX_MAX;
    return s[PIX_W-1:0];
  endfunction

  // Stage 1: two scaled products.
  logic             s1_valid;
  logic [PIX_W-1:0] s1_host;
  logic [PW-1:0]    s1_host_term;
  logic [PW-1:0]    s1_wm_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid     <= 1'b0;
      s1_host      <= '0;
      s1_host_term <= '0;
      s1_wm_term   <= '0;
    end else begin
      s1_valid     <= in_valid;
      s1_host      <= in_host;
      s1_host_term <= f_scale(coef, in_host);
      s1_wm_term   <= f_scale(strength, in_wm);
    end
  end

  // Stage 2: product of products, integer part only.
  logic             s2_valid;
  logic [PIX_W-1:0] s2_host;
  logic [DW-1:0]    s2_delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_host  <= '0;
      s2_delta <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_host  <= s1_host;
      s2_delta <= f_merge(s1_host_term, s1_wm_term);
    end
  end

  // Stage 3: saturating add, output held while no pixel arrives.
  logic [PIX_W-1:0] s3_sum;
  assign s3_sum = f_sat_add(s2_host, s2_delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) out_pix <= s3_sum;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> (out_pix >= $past(s2_host))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> $stable(out_pix)); // R9

endmodule

// File: rtl/vis_wm_embedder.sv
module vis_wm_embedder #(
  parameter int NUM_BANDS = 4,
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 8,
  parameter int CFG_AW    = $clog2(2 * NUM_BANDS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_host,
  input  logic [PIX_W-1:0]  in_wm,
  input  logic [COEF_W-1:0] wm_strength,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  output logic [COEF_W-1:0] cfg_rdata,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int LAT = 3;

  logic [NUM_BANDS-1:0][COEF_W-1:0] coef_vec;
  logic [NUM_BANDS-2:0][PIX_W-1:0]  thr_vec;
  logic [COEF_W-1:0]                band_coef;

  vwm_const_rf #(
    .NUM_BANDS(NUM_BANDS), .PIX_W(PIX_W), .COEF_W(COEF_W), .AW(CFG_AW)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .coef_vec (coef_vec),
    .thr_vec  (thr_vec)
  );

  vwm_range_sel #(
    .NUM_BANDS(NUM_BANDS), .PIX_W(PIX_W), .COEF_W(COEF_W)
  ) u_sel (
    .host     (in_host),
    .thr_vec  (thr_vec),
    .coef_vec (coef_vec),
    .coef_sel (band_coef)
  );

  vwm_mac_pipe #(
    .PIX_W(PIX_W), .COEF_W(COEF_W)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_host   (in_host),
    .in_wm     (in_wm),
    .coef      (band_coef),
    .strength  (wm_strength),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  // Cycles since reset, saturating at the pipeline depth, for the checks.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (int'(age) < LAT) age <= age + 2'd1;
  end

  logic pipe_full;
  assign pipe_full = (int'(age) == LAT);

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> (out_valid == $past(in_valid, 3))); // R6

  AST_ZERO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_full && out_valid && (($past(in_wm, 3) == '0) || ($past(wm_strength, 3) == '0)))
      |-> (out_pix == $past(in_host, 3))); // R7

endmodule

// File: tb/vis_wm_embedder_bench.sv
module vis_wm_embedder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_host = '0;
  logic [7:0] in_wm = '0;
  logic [7:0] wm_strength = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       out_valid;
  logic [7:0] out_pix;

  always #10 clk = ~clk;

  vis_wm_embedder u_vis_wm_embedder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_host(in_host),
    .in_wm(in_wm), .wm_strength(wm_strength), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_vec = 0;
  int n_bad = 0;
  int m_rf [7] = '{87, 56, 48, 44, 64, 128, 192};
  logic hv [3] = '{1'b0, 1'b0, 1'b0};
  int   he [3] = '{0, 0, 0};
  int   last_out = 0;

  function automatic int ref_pix(int h, int w, int s);
    int  band;
    longint p;
    int  r;
    band = 0;
    for (int i = 0; i < 3; i++) if (h >= m_rf[4+i]) band++;
    p = longint'(m_rf[band]) * h * s * w;
    r = h + int'(p >>> 16);
    return (r > 255) ? 255 : r;
  endfunction

  task automatic check_out();
    n_vec++;
    if (hv[2]) begin
      if (!out_valid || int'(out_pix) != he[2]) begin
        n_bad++;
        $display("FAIL R4/R6 valid=%0d pix=%0d expected valid=1 pix=%0d", out_valid, out_pix, he[2]);
      end
      last_out = he[2];
    end else begin
      if (out_valid || int'(out_pix) != last_out) begin
        n_bad++;
        $display("FAIL R9 valid=%0d pix=%0d expected valid=0 pix=%0d", out_valid, out_pix, last_out);
      end
    end
  endtask

  // One cycle: check the pixel issued three cycles ago, then drive a new one.
  task automatic step(input logic v, input int h, input int w, input int s,
                      input logic we, input int a, input int d);
    @(negedge clk);
    check_out();
    hv[2] = hv[1]; he[2] = he[1];
    hv[1] = hv[0]; he[1] = he[0];
    hv[0] = v;
    he[0] = v ? ref_pix(h, w, s) : 0;   // R8: same-cycle write not yet seen
    in_valid = v; in_host = 8'(h); in_wm = 8'(w); wm_strength = 8'(s);
    cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    if (we && a < 7) m_rf[a] = d;
  endtask

  task automatic read_check(input int a, input int exp, input string tag);
    cfg_addr = 3'(a);
    #1;
    n_vec++;
    if (int'(cfg_rdata) != exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d rdata=%0d expected=%0d", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic sweep(input int nw, input int ns);
    int wl [6] = '{0, 1, 37, 128, 200, 255};
    int sl [4] = '{0, 8, 128, 255};
    int n = 0;
    for (int h = 0; h < 256; h++)
      for (int wi = 0; wi < nw; wi++)
        for (int si = 0; si < ns; si++) begin
          // R3 R4 R5 R6 R7: full host sweep crosses every threshold edge
          step(1'b1, h, wl[wi], sl[si], 1'b0, 0, 0);
          n++;
          if (n % 7 == 6) step(1'b0, 8'hA5, 8'h5A, 255, 1'b0, 0, 0); // R9 gap
        end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state of outputs and store
    n_vec++;
    if (out_valid || out_pix != 8'd0) begin
      n_bad++;
      $display("FAIL R1 valid=%0d pix=%0d expected valid=0 pix=0", out_valid, out_pix);
    end
    for (int a = 0; a < 7; a++) read_check(a, m_rf[a], "R1");
    read_check(7, 0, "R2");

    // R2: write to the unmapped address leaves the store unchanged
    step(1'b0, 0, 0, 0, 1'b1, 7, 8'hEE);
    step(1'b0, 0, 0, 0, 1'b0, 0, 0);
    for (int a = 0; a < 8; a++) read_check(a, (a < 7) ? m_rf[a] : 0, "R2");

    sweep(6, 4);

    // R8: write band-1 coefficient to 0 in the same cycle as a band-1 pixel
    step(1'b1, 100, 255, 128, 1'b1, 1, 0);
    step(1'b1, 100, 255, 128, 1'b0, 0, 0);
    step(1'b1, 100, 255, 255, 1'b0, 0, 0);

    // R2 R3: close, uneven thresholds and extreme coefficients
    step(1'b0, 0, 0, 0, 1'b1, 0, 1);
    step(1'b0, 0, 0, 0, 1'b1, 1, 255);
    step(1'b0, 0, 0, 0, 1'b1, 2, 3);
    step(1'b0, 0, 0, 0, 1'b1, 3, 0);
    step(1'b0, 0, 0, 0, 1'b1, 4, 10);
    step(1'b0, 0, 0, 0, 1'b1, 5, 11);
    step(1'b0, 0, 0, 0, 1'b1, 6, 250);
    step(1'b0, 0, 0, 0, 1'b0, 0, 0);
    for (int a = 0; a < 7; a++) read_check(a, m_rf[a], "R2");

    sweep(6, 2);

    repeat (4) step(1'b0, 0, 0, 0, 1'b0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule